// File: doc/BRIEF.md
# Command/Response FIFO Engine

This block sits behind a host register window and moves one command in and one response out through a single byte-wide data port. The host reads a status byte to learn what the engine wants next. It writes command bytes into the data port while the engine asks for more. It then starts execution and reads the response bytes back through the same port. A dynamic burst count tells the host how many bytes it may move without polling again.

Both the command and the response carry a 10-byte header. Bytes 2 to 5 of that header hold the total length, most significant byte first. The engine reads that field as the bytes stream past. It clamps the length to the range from 10 bytes to the buffer depth and uses the result to end the transfer. A stub executor stands in for real command processing. After a programmable delay it loads a fixed 10-byte response into the shared buffer.

An external arbiter names the active locality. Accesses tagged with any other locality are ignored. Writing the command-ready bit returns the engine to the ready state from any state. When a transfer is in progress, that write aborts it.

States: IDLE (after reset), READY (empty buffer, waiting for the first command byte), RECV (command partly received), FULL (command complete, waiting for go), EXEC (stub executor running), RESP (response held in the buffer). Transitions: IDLE to READY on a command-ready write; READY to RECV on the first data write; RECV to FULL when the byte count reaches the clamped length; FULL to EXEC on a go write; EXEC to RESP when the stub has loaded its last byte; RECV, FULL, EXEC and RESP to READY on a command-ready write (abort); READY to READY on a command-ready write.

Top module: `cmdfifo_engine`

## Requirements
- R1: After reset the engine is in IDLE, the status byte reads 0x80, the burst count reads 0 and ovf_flag is 0.
- R2: Register offsets within the window are 0x18 for the status byte, 0x19 for the burst count low byte, 0x1A for the burst count high byte and 0x24 for the data port. Status bits are valid=bit 7, command-ready=bit 6, go=bit 5 (always reads 0), data-available=bit 4 and expect=bit 3. A write with bit 6 set moves IDLE to READY, and the status then reads 0xC0.
- R3: A data-port write in READY or RECV is stored. After each stored byte n, expect reads 1 (status 0x88) while n is below the target and 0 (status 0x80) once n equals the target. The target is the big-endian length in bytes 2 to 5, clamped to at least 10 and at most DEPTH.
- R4: The burst count is DEPTH in READY, DEPTH minus the bytes stored in RECV, the unread response bytes in RESP and 0 in every other state. It never exceeds DEPTH.
- R5: A status write with bit 5 set and bit 6 clear moves FULL to EXEC. In every other state it has no effect. In EXEC the status byte reads 0x00.
- R6: Data-available first reads 1 (status 0x90) exactly exec_cycles+11 clock edges after the edge that accepts go. The response bytes are 0x80, 0x01, 0x00, 0x00, 0x00, 0x0A, 0x00, 0x00, 0x00, 0x00.
- R7: Data-port reads in RESP return the response bytes in order. Once the host has read the length taken from the response header, the status reads 0x80. Further reads return 0xFF and change nothing.
- R8: A status write with bit 6 set aborts RECV, FULL, EXEC or RESP. The engine returns to READY with status 0xC0, burst count DEPTH and ovf_flag 0, and an aborted execution never produces a response.
- R9: A data-port write outside READY and RECV is dropped. It sets ovf_flag and leaves the status byte and the burst count unchanged.
- R10: An access is ignored when active_vld is 0 or acc_loc differs from active_loc. Such a write changes nothing and such a read returns 0xFF.
- R11: A status write with both bit 6 and bit 5 set acts as command-ready only. In FULL it returns the engine to READY rather than starting execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_vld | input | 1 | Arbiter has granted a locality |
| active_loc | input | LOC_W | Locality granted by the arbiter |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_loc | input | LOC_W | Locality the access comes from |
| acc_off | input | OFF_W | Byte offset within the locality window |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid during the access cycle |
| exec_cycles | input | DLY_W | Stub executor delay before the response load |
| ovf_flag | output | 1 | Sticky flag for a dropped data-port write |

## Verification
The bench builds the engine with DEPTH set to 16, so every command length from 0 to 20 can be swept: values below the 10-byte header, every value inside the buffer and values that are clamped at the buffer edge. Length words with only the high byte set, or with bit 8 set, confirm that the field is read most significant byte first. Executor delays from 0 to 3 are measured to the exact cycle. Aborts from every busy state, dropped writes in every non-receiving state and foreign-locality accesses are also checked.

// File: rtl/cmdfifo_pkg.sv
package cmdfifo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READY,
        ST_RECV,
        ST_FULL,
        ST_EXEC,
        ST_RESP
    } eng_state_t;

    typedef enum logic [1:0] {
        SX_OFF,
        SX_WAIT,
        SX_LOAD
    } stub_phase_t;

    // register offsets inside one locality window
    localparam int OFF_STS     = 'h018;
    localparam int OFF_BURST_L = 'h019;
    localparam int OFF_BURST_H = 'h01A;
    localparam int OFF_FIFO    = 'h024;

    // status byte bit positions
    localparam int B_VALID  = 7;
    localparam int B_CRDY   = 6;
    localparam int B_GO     = 5;
    localparam int B_AVAIL  = 4;
    localparam int B_EXPECT = 3;

    // header layout
    localparam int HDR_BYTES = 10;
    localparam int LEN_FIRST = 2;
    localparam int LEN_LAST  = 5;

    // fixed reply produced by the stub executor
    function automatic logic [7:0] stub_resp_byte(input int idx);
        logic [7:0] b;
        case (idx)
            0:       b = 8'h80;
            1:       b = 8'h01;
            5:       b = 8'(HDR_BYTES);
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cmdfifo_buf.sv
module cmdfifo_buf #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/cmdfifo_lenparse.sv
module cmdfifo_lenparse
    import cmdfifo_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       data,
    output logic [31:0]      len
);

    // bytes LEN_FIRST..LEN_LAST carry the length, most significant first
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            len <= '0;
        end else if (en) begin
            for (int k = LEN_FIRST; k <= LEN_LAST; k++) begin
                if (idx == IDX_W'(k)) begin
                    len[8*(LEN_LAST-k) +: 8] <= data;
                end
            end
        end
    end

endmodule

// File: rtl/cmdfifo_stub.sv
module cmdfifo_stub
    import cmdfifo_pkg::*;
#(
    parameter int DLY_W = 16,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [DLY_W-1:0] delay,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             done
);

    stub_phase_t      phase;
    logic [DLY_W-1:0] cnt;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            phase <= SX_OFF;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            unique case (phase)
                SX_OFF: begin
                    if (start) begin
                        phase <= SX_WAIT;
                        cnt   <= '0;
                    end
                end
                SX_WAIT: begin
                    if (cnt == delay) begin
                        phase <= SX_LOAD;
                        idx   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SX_LOAD: begin
                    if (idx == IDX_W'(HDR_BYTES - 1)) begin
                        phase <= SX_OFF;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: phase <= SX_OFF;
            endcase
        end
    end

    always_comb begin
        wr_en   = (phase == SX_LOAD);
        wr_idx  = idx;
        wr_data = stub_resp_byte(int'(idx));
        done    = (phase == SX_LOAD) && (idx == IDX_W'(HDR_BYTES - 1));
    end

endmodule

// File: rtl/cmdfifo_engine.sv
module cmdfifo_engine
    import cmdfifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LOC_W = 3,
    parameter int OFF_W = 12,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_vld,
    input  logic [LOC_W-1:0] active_loc,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [LOC_W-1:0] acc_loc,
    input  logic [OFF_W-1:0] acc_off,
    input  logic [7:0]       acc_wdata,
    output logic [7:0]       acc_rdata,
    input  logic [DLY_W-1:0] exec_cycles,
    output logic             ovf_flag
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    function automatic logic [CNT_W-1:0] clamp_len(input logic [31:0] l);
        logic [CNT_W-1:0] r;
        if (l > 32'(DEPTH)) begin
            r = CNT_W'(DEPTH);
        end else if (l < 32'(HDR_BYTES)) begin
            r = CNT_W'(HDR_BYTES);
        end else begin
            r = l[CNT_W-1:0];
        end
        return r;
    endfunction

    eng_state_t       state, st_n;
    logic [CNT_W-1:0] rx_cnt, rd_cnt;
    logic [31:0]      cmd_len, resp_len;
    logic [CNT_W-1:0] cmd_tgt, resp_tgt;
    logic [7:0]       sts_byte;
    logic [15:0]      burst;
    logic [7:0]       buf_rdata;

    // access decode
    logic hit, sel_sts, sel_bl, sel_bh, sel_fifo;
    logic crdy_wr, go_wr, fifo_wr, fifo_rd;
    logic rx_ok, rx_last, tx_ok, resp_avail;
    logic [CNT_W-1:0] rx_next;

    // stub executor handshake
    logic             ex_start, ex_wr_en, ex_done;
    logic [IDX_W-1:0] ex_idx;
    logic [7:0]       ex_data;

    // shared buffer write port
    logic             b_we;
    logic [IDX_W-1:0] b_widx;
    logic [7:0]       b_wdata;

    always_comb begin
        hit      = acc_valid && active_vld && (acc_loc == active_loc);
        sel_sts  = (acc_off == OFF_W'(OFF_STS));
        sel_bl   = (acc_off == OFF_W'(OFF_BURST_L));
        sel_bh   = (acc_off == OFF_W'(OFF_BURST_H));
        sel_fifo = (acc_off == OFF_W'(OFF_FIFO));
        crdy_wr  = hit && acc_write && sel_sts && acc_wdata[B_CRDY];
        go_wr    = hit && acc_write && sel_sts && acc_wdata[B_GO] && !acc_wdata[B_CRDY];
        fifo_wr  = hit && acc_write && sel_fifo;
        fifo_rd  = hit && !acc_write && sel_fifo;

        cmd_tgt    = clamp_len(cmd_len);
        resp_tgt   = clamp_len(resp_len);
        rx_ok      = fifo_wr && ((state == ST_READY) || (state == ST_RECV));
        rx_next    = rx_cnt + 1'b1;
        rx_last    = rx_ok && (rx_next >= cmd_tgt);
        resp_avail = (state == ST_RESP) && (rd_cnt < resp_tgt);
        tx_ok      = fifo_rd && resp_avail;
        ex_start   = (state == ST_FULL) && go_wr;
    end

    // next-state logic
    always_comb begin
        st_n = state;
        unique case (state)
            ST_IDLE:  if (crdy_wr) st_n = ST_READY;
            ST_READY: begin
                if (rx_ok) st_n = rx_last ? ST_FULL : ST_RECV;
            end
            ST_RECV: begin
                if (crdy_wr)      st_n = ST_READY;
                else if (rx_last) st_n = ST_FULL;
            end
            ST_FULL: begin
                if (crdy_wr)    st_n = ST_READY;
                else if (go_wr) st_n = ST_EXEC;
            end
            ST_EXEC: begin
                if (crdy_wr)      st_n = ST_READY;
                else if (ex_done) st_n = ST_RESP;
            end
            ST_RESP:  if (crdy_wr) st_n = ST_READY;
            default:  st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= st_n;
        end
    end

    // byte counters and drop flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cnt   <= '0;
            rd_cnt   <= '0;
            ovf_flag <= 1'b0;
        end else if (crdy_wr) begin
            rx_cnt   <= '0;
            rd_cnt   <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (rx_ok) begin
                rx_cnt <= rx_next;
            end
            if (tx_ok) begin
                rd_cnt <= rd_cnt + 1'b1;
            end
            if (fifo_wr && !rx_ok) begin
                ovf_flag <= 1'b1;
            end
        end
    end

    // output process: status byte, burst count, read data
    always_comb begin
        sts_byte           = '0;
        sts_byte[B_VALID]  = (state != ST_EXEC);
        sts_byte[B_CRDY]   = (state == ST_READY);
        sts_byte[B_AVAIL]  = resp_avail;
        sts_byte[B_EXPECT] = (state == ST_RECV);

        unique case (state)
            ST_READY: burst = 16'(DEPTH);
            ST_RECV:  burst = 16'(DEPTH) - 16'(rx_cnt);
            ST_RESP:  burst = resp_avail ? (16'(resp_tgt) - 16'(rd_cnt)) : 16'd0;
            default:  burst = 16'd0;
        endcase

        if (!hit || acc_write) begin
            acc_rdata = 8'hFF;
        end else if (sel_sts) begin
            acc_rdata = sts_byte;
        end else if (sel_bl) begin
            acc_rdata = burst[7:0];
        end else if (sel_bh) begin
            acc_rdata = burst[15:8];
        end else if (sel_fifo) begin
            acc_rdata = resp_avail ? buf_rdata : 8'hFF;
        end else begin
            acc_rdata = 8'h00;
        end
    end

    // shared buffer: host path fills it in receive, stub fills it in exec
    always_comb begin
        b_we    = rx_ok || ex_wr_en;
        b_widx  = ex_wr_en ? ex_idx : rx_cnt[IDX_W-1:0];
        b_wdata = ex_wr_en ? ex_data : acc_wdata;
    end

    cmdfifo_buf #(
        .DEPTH (DEPTH)
    ) u_buf (
        .clk   (clk),
        .we    (b_we),
        .widx  (b_widx),
        .wdata (b_wdata),
        .ridx  (rd_cnt[IDX_W-1:0]),
        .rdata (buf_rdata)
    );

    cmdfifo_lenparse #(
        .IDX_W (IDX_W)
    ) u_cmd_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crdy_wr),
        .en    (rx_ok),
        .idx   (rx_cnt[IDX_W-1:0]),
        .data  (acc_wdata),
        .len   (cmd_len)
    );

    cmdfifo_lenparse #(
        .IDX_W (IDX_W)
    ) u_resp_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crdy_wr),
        .en    (ex_wr_en),
        .idx   (ex_idx),
        .data  (ex_data),
        .len   (resp_len)
    );

    cmdfifo_stub #(
        .DLY_W (DLY_W),
        .IDX_W (IDX_W)
    ) u_stub (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ex_start),
        .abort   (crdy_wr),
        .delay   (exec_cycles),
        .wr_en   (ex_wr_en),
        .wr_idx  (ex_idx),
        .wr_data (ex_data),
        .done    (ex_done)
    );

endmodule

// File: rtl/cmdfifo_engine_chk.sv
module cmdfifo_engine_chk
    import cmdfifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LOC_W = 3,
    parameter int OFF_W = 12,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             active_vld,
    input logic [LOC_W-1:0] active_loc,
    input logic             acc_valid,
    input logic             acc_write,
    input logic [LOC_W-1:0] acc_loc,
    input logic [OFF_W-1:0] acc_off,
    input logic [7:0]       acc_wdata,
    input eng_state_t       state,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [CNT_W-1:0] rd_cnt,
    input logic [15:0]      burst,
    input logic [7:0]       sts_byte,
    input logic             ovf_flag
);

    logic foreign, own_wr, abort_wr, drop_wr;

    always_comb begin
        foreign  = acc_valid && !(active_vld && (acc_loc == active_loc));
        own_wr   = acc_valid && acc_write && !foreign;
        abort_wr = own_wr && (acc_off == OFF_W'(OFF_STS)) && acc_wdata[B_CRDY];
        drop_wr  = own_wr && (acc_off == OFF_W'(OFF_FIFO))
                   && (state != ST_READY) && (state != ST_RECV);
    end

    assert_foreign_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        foreign |=> $stable(state) && $stable(rx_cnt) && $stable(rd_cnt) && $stable(ovf_flag));

    assert_abort_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_wr |=> (state == ST_READY) && (rx_cnt == '0) && (rd_cnt == '0) && !ovf_flag);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drop_wr |=> ovf_flag && $stable(rx_cnt) && $stable(state));

    assert_burst_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(burst) <= 32'(DEPTH));

    assert_sts_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sts_byte[B_CRDY], sts_byte[B_AVAIL], sts_byte[B_EXPECT]}));

    assert_recv_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV) |-> (32'(rx_cnt) < 32'(DEPTH)));

endmodule

bind cmdfifo_engine cmdfifo_engine_chk #(
    .DEPTH (DEPTH),
    .LOC_W (LOC_W),
    .OFF_W (OFF_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_vld (active_vld),
    .active_loc (active_loc),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_loc    (acc_loc),
    .acc_off    (acc_off),
    .acc_wdata  (acc_wdata),
    .state      (state),
    .rx_cnt     (rx_cnt),
    .rd_cnt     (rd_cnt),
    .burst      (burst),
    .sts_byte   (sts_byte),
    .ovf_flag   (ovf_flag)
);

// File: tb/cmdfifo_engine_bench.sv
module cmdfifo_engine_bench;

    localparam int DEPTH = 16;
    localparam int HDR   = 10;
    localparam logic [11:0] A_STS = 12'h018;
    localparam logic [11:0] A_BL  = 12'h019;
    localparam logic [11:0] A_BH  = 12'h01A;
    localparam logic [11:0] A_FF  = 12'h024;
    localparam logic [2:0]  LOC   = 3'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        active_vld = 1'b1;
    logic [2:0]  active_loc = LOC;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [2:0]  acc_loc = LOC;
    logic [11:0] acc_off = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic [15:0] exec_cycles = '0;
    logic        ovf_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cmdfifo_engine #(.DEPTH(DEPTH)) u_cmdfifo_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_vld  (active_vld),
        .active_loc  (active_loc),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_loc     (acc_loc),
        .acc_off     (acc_off),
        .acc_wdata   (acc_wdata),
        .acc_rdata   (acc_rdata),
        .exec_cycles (exec_cycles),
        .ovf_flag    (ovf_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [2:0] loc, input logic [11:0] off,
                          input logic [7:0] d, output logic [7:0] r);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = w;
        acc_loc   = loc;
        acc_off   = off;
        acc_wdata = d;
        #1 r = acc_rdata;
        @(posedge clk);
        #1 acc_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] off, input logic [7:0] d);
        logic [7:0] r;
        access(1'b1, LOC, off, d, r);
    endtask

    task automatic rd(input logic [11:0] off, output logic [7:0] r);
        access(1'b0, LOC, off, 8'h00, r);
    endtask

    task automatic rd_burst(output logic [15:0] b);
        logic [7:0] lo, hi;
        rd(A_BL, lo);
        rd(A_BH, hi);
        b = {hi, lo};
    endtask

    function automatic int clamp(input logic [31:0] l);
        if (l > 32'(DEPTH)) return DEPTH;
        if (l < 32'(HDR)) return HDR;
        return int'(l);
    endfunction

    function automatic logic [7:0] cmd_byte(input int i, input logic [31:0] lf);
        if (i >= 2 && i <= 5) return lf[8*(5-i) +: 8];
        return 8'(i * 7 + 3);
    endfunction

    function automatic logic [7:0] exp_resp(input int i);
        if (i == 0) return 8'h80;
        if (i == 1) return 8'h01;
        if (i == 5) return 8'h0A;
        return 8'h00;
    endfunction

    // send a whole command, checking expect and burst count after each byte
    task automatic send_cmd(input logic [31:0] lf);
        logic [7:0]  s;
        logic [15:0] b;
        int tgt = clamp(lf);
        for (int n = 1; n <= tgt; n++) begin
            wr(A_FF, cmd_byte(n - 1, lf));
            rd(A_STS, s);
            check("R3 expect flag", s, (n < tgt) ? 8'h88 : 8'h80);
            rd_burst(b);
            check("R4 burst in receive", b, (n < tgt) ? 16'(DEPTH - n) : 16'd0);
        end
    endtask

    task automatic start_and_wait(input int dly);
        logic [7:0] s;
        int k = 0;
        exec_cycles = 16'(dly);
        wr(A_STS, 8'h20);
        do begin
            rd(A_STS, s);
            k++;
        end while (!s[4] && k < 200);
        check("R6 response latency", k, dly + 12);
        check("R6 status with response", s, 8'h90);
    endtask

    task automatic full_run(input logic [31:0] lf, input int dly);
        logic [7:0]  s, r;
        logic [15:0] b;
        send_cmd(lf);
        wr(A_FF, 8'h5A);
        check("R9 drop sets flag", ovf_flag, 1'b1);
        rd(A_STS, s);
        check("R9 status unchanged", s, 8'h80);
        rd_burst(b);
        check("R9 burst unchanged", b, 16'd0);
        start_and_wait(dly);
        rd_burst(b);
        check("R4 burst in response", b, 16'd10);
        for (int i = 0; i < 10; i++) begin
            rd(A_FF, r);
            check("R7 response byte", r, exp_resp(i));
            rd_burst(b);
            check("R4 burst after read", b, 16'(9 - i));
        end
        rd(A_STS, s);
        check("R7 drained status", s, 8'h80);
        rd(A_FF, r);
        check("R7 read past end", r, 8'hFF);
        rd(A_STS, s);
        check("R7 status after extra read", s, 8'h80);
        wr(A_STS, 8'h40);
        rd(A_STS, s);
        check("R8 back to ready", s, 8'hC0);
        check("R8 flag cleared", ovf_flag, 1'b0);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog (all requirements) act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  s, r;
        logic [15:0] b;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(A_STS, s);
        check("R1 reset status", s, 8'h80);
        rd_burst(b);
        check("R1 reset burst", b, 16'd0);
        check("R1 reset flag", ovf_flag, 1'b0);

        // R10 foreign locality and no grant
        access(1'b1, 3'd1, A_STS, 8'h40, r);
        rd(A_STS, s);
        check("R10 foreign write ignored", s, 8'h80);
        access(1'b0, 3'd1, A_STS, 8'h00, r);
        check("R10 foreign read", r, 8'hFF);
        active_vld = 1'b0;
        wr(A_STS, 8'h40);
        rd(A_STS, r);
        check("R10 no grant read", r, 8'hFF);
        active_vld = 1'b1;
        rd(A_STS, s);
        check("R10 no grant write ignored", s, 8'h80);

        // R2 command-ready from idle
        wr(A_STS, 8'h40);
        rd(A_STS, s);
        check("R2 ready status", s, 8'hC0);
        rd_burst(b);
        check("R4 burst in ready", b, 16'(DEPTH));

        // R5 go outside FULL is ignored
        wr(A_STS, 8'h20);
        rd(A_STS, s);
        check("R5 go in ready ignored", s, 8'hC0);

        // main sweep over command lengths and delays
        for (int l = 0; l <= 20; l++) begin
            full_run(32'(l), l % 4);
        end
        full_run(32'h0C00_0000, 1);
        full_run(32'h0000_0100, 0);
        full_run(32'h0000_000C, 2);

        // R8 abort during receive
        for (int i = 0; i < 5; i++) wr(A_FF, cmd_byte(i, 32'd12));
        wr(A_STS, 8'h40);
        rd(A_STS, s);
        check("R8 abort in receive", s, 8'hC0);
        rd_burst(b);
        check("R8 burst after abort", b, 16'(DEPTH));

        // R11 both bits in FULL
        send_cmd(32'd10);
        wr(A_STS, 8'h60);
        rd(A_STS, s);
        check("R11 command-ready wins", s, 8'hC0);

        // R5 + R8 abort during execution
        send_cmd(32'd10);
        exec_cycles = 16'd20;
        wr(A_STS, 8'h20);
        rd(A_STS, s);
        check("R5 status in exec", s, 8'h00);
        wr(A_FF, 8'h11);
        check("R9 drop in exec", ovf_flag, 1'b1);
        wr(A_STS, 8'h40);
        repeat (50) @(posedge clk);
        rd(A_STS, s);
        check("R8 abort in exec", s, 8'hC0);

        // R8 abort during response
        send_cmd(32'd10);
        start_and_wait(0);
        for (int i = 0; i < 3; i++) rd(A_FF, r);
        wr(A_STS, 8'h40);
        rd(A_STS, s);
        check("R8 abort in response", s, 8'hC0);
        rd_burst(b);
        check("R8 burst after response abort", b, 16'(DEPTH));

        summary();
        $finish;
    end

endmodule